// File: doc/BRIEF.md
# Seven-Source Interrupt Flag and Mask Unit

This block collects seven interrupt sources into one active-high request line. Four come from external control lines, grouped as two ports (A and B) with one primary and one secondary line each. Each line passes through a synchronizer and an edge detector whose polarity and mode are chosen in an edge-configuration register. The other three sources are single-cycle pulses from a neighbouring shift register and two timers. Each source has a sticky flag and an enable bit. The request output is high while any source has both its flag and its enable set.

Software reaches three registers over a small strobe bus: the flag register, the enable register and the edge-configuration register. Writes to the enable register use bit 7 to choose between set and clear, so individual sources can be changed without a read-modify-write. Flags clear on a write of one. A build-time parameter selects a variant in which such a clear happens only when bit 7 of the written byte is also 1. Pulses from the port data logic also clear the port's flags, unless a secondary line is in independent mode.

Top module: `irqflag_ctrl`

## Requirements
- R1: After reset, the flags, the enables and the edge configuration are all zero and `irq` is low. Reading the enable register returns 0x80, and reading the flag register returns 0x00.
- R2: A write to the enable register (address 1) with bit 7 = 1 sets every enable whose data bit is 1 and leaves the others unchanged. Read data shows the enables in bits 6:0 and a 1 in bit 7.
- R3: A write to the enable register with bit 7 = 0 clears every enable whose data bit is 1, so a write of 0x7F disables all seven sources.
- R4: With `CLR_NEEDS_B7` = 0, a write to the flag register (address 0) clears every flag whose data bit is 1, and 0x7F clears all of them.
- R5: With `CLR_NEEDS_B7` = 1, a write to the flag register clears flags only when bit 7 of the data is 1. With bit 7 = 0 the write changes no flag.
- R6: `irq` is the OR of (flags AND enables) over bits 6:0. A read of the flag register returns the flags in bits 6:0 and that same OR in bit 7.
- R7: A pulse on `tmr1_evt`, `tmr2_evt` or `shift_evt` sets flag bit 6, 5 or 2 respectively, visible one cycle after the pulse.
- R8: The primary line of port A sets flag bit 1 and that of port B sets bit 4. The active edge is falling when configuration bit 0 (A) or bit 4 (B) is 0, and rising when that bit is 1. The flag is set on the third clock edge after the line changes.
- R9: The mode of the secondary line of port A is configuration bits 3:1 and that of port B is bits 7:5. The two lines set flag bits 0 and 3. Within a mode: bit 2 = 1 means the line sets no flag; bit 1 chooses rising (1) or falling (0); bit 0 chooses independent (1). So 0x66 gives rising independent lines and 0x22 gives falling independent lines.
- R10: A pulse on `port_a_access` clears flag bit 1, and clears bit 0 only when the port A secondary line is not independent. `port_b_access` does the same for bits 4 and 3.
- R11: When an event sets a flag in the same cycle as a write that clears it, the flag ends set.
- R12: A flag is set whether or not its enable is set. It keeps `irq` low while disabled, and raises `irq` as soon as its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Register select: 0 flags, 1 enables, 2 edge configuration |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe; `rd_data` is updated on the next clock edge |
| rd_data | output | 8 | Registered read data |
| line_a_pri | input | 1 | Port A primary control line |
| line_a_sec | input | 1 | Port A secondary control line |
| line_b_pri | input | 1 | Port B primary control line |
| line_b_sec | input | 1 | Port B secondary control line |
| port_a_access | input | 1 | Pulse: port A data was accessed |
| port_b_access | input | 1 | Pulse: port B data was accessed |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| tmr2_evt | input | 1 | Timer 2 event pulse |
| shift_evt | input | 1 | Shift register event pulse |
| irq | output | 1 | Active-high summary interrupt request |

## Verification
Results arrive at different latencies, and each check is placed at the cycle its path allows. Register writes, event pulses and port-access pulses take effect on the clock edge that samples them. `irq` follows combinationally from the flag and enable registers, and read data is registered, so it appears one edge after the read strobe. A control-line change needs two synchronizer edges plus the flag edge. The bench therefore drives every input just after a falling clock edge. It samples register effects at the next falling edge and waits three falling edges after a line change before it reads the flags. Some steps check that an edge in the wrong direction, or a line in output mode, sets no flag; those steps wait the same three edges before reading the flags.

// File: rtl/irqflag_pkg.sv
package irqflag_pkg;
  localparam int unsigned NSRC      = 7;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NPORT     = 2;
  localparam int unsigned NLINE     = 2 * NPORT;
  // bit positions decoded by software
  localparam int unsigned SRC_SHIFT = 2;
  localparam int unsigned SRC_TMR2  = 5;
  localparam int unsigned SRC_TMR1  = 6;

  typedef enum logic [1:0] {
    SEL_FLAGS   = 2'd0,
    SEL_ENABLES = 2'd1,
    SEL_EDGECFG = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pri_rise;
    logic sec_on;
    logic sec_rise;
    logic sec_indep;
  } port_cfg_t;
endpackage

// File: rtl/irqflag_edge.sv
module irqflag_edge #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   cur;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_in};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      prev_q <= IDLE_LEVEL;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;
endmodule

// File: rtl/irqflag_lcfg.sv
module irqflag_lcfg
  import irqflag_pkg::*;
(
  input  logic [DATA_W-1:0]          cfg,
  output port_cfg_t [NPORT-1:0]      port_cfg
);
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam int unsigned BASE = 4 * g;
    assign port_cfg[g].pri_rise  = cfg[BASE];
    assign port_cfg[g].sec_indep = cfg[BASE+1];
    assign port_cfg[g].sec_rise  = cfg[BASE+2];
    assign port_cfg[g].sec_on    = ~cfg[BASE+3];
  end
endmodule

// File: rtl/irqflag_regs.sv
module irqflag_regs
  import irqflag_pkg::*;
#(
  parameter bit CLR_NEEDS_B7 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   set_vec,
  input  logic [NSRC-1:0]   port_clr_vec,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   enables,
  output logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [NSRC-1:0]   flags_q, flags_d, enables_q, enables_d, clr_vec;
  logic [DATA_W-1:0] cfg_q, cfg_d, rd_q, rd_d;
  logic              wr_flags, wr_en_reg, wr_cfg, clr_gate, any_pend;

  always_comb begin
    wr_flags  = wr_en && (sel == SEL_FLAGS);
    wr_en_reg = wr_en && (sel == SEL_ENABLES);
    wr_cfg    = wr_en && (sel == SEL_EDGECFG);
    clr_gate  = !CLR_NEEDS_B7 || wdata[DATA_W-1];
    clr_vec   = (wr_flags && clr_gate) ? wdata[NSRC-1:0] : '0;
    // a new event outranks any clear in the same cycle
    flags_d   = (flags_q & ~clr_vec & ~port_clr_vec) | set_vec;
    enables_d = wdata[DATA_W-1] ? (enables_q | wdata[NSRC-1:0])
                                : (enables_q & ~wdata[NSRC-1:0]);
    cfg_d     = wdata;
    any_pend  = |(flags_q & enables_q);
    unique case (sel)
      SEL_FLAGS:   rd_d = {any_pend, flags_q};
      SEL_ENABLES: rd_d = {1'b1, enables_q};
      SEL_EDGECFG: rd_d = cfg_q;
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      enables_q <= '0;
      cfg_q     <= '0;
      rd_q      <= '0;
    end else begin
      flags_q <= flags_d;
      if (wr_en_reg) enables_q <= enables_d;
      if (wr_cfg)    cfg_q     <= cfg_d;
      if (rd_en)     rd_q      <= rd_d;
    end
  end

  assign flags   = flags_q;
  assign enables = enables_q;
  assign cfg     = cfg_q;
  assign rd_data = rd_q;
  assign irq     = any_pend;
endmodule

// File: rtl/irqflag_ctrl.sv
module irqflag_ctrl
  import irqflag_pkg::*;
#(
  parameter int unsigned ADDR_W       = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          CLR_NEEDS_B7 = 1'b0,
  parameter logic        IDLE_LEVEL   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic              line_a_pri,
  input  logic              line_a_sec,
  input  logic              line_b_pri,
  input  logic              line_b_sec,
  input  logic              port_a_access,
  input  logic              port_b_access,
  input  logic              tmr1_evt,
  input  logic              tmr2_evt,
  input  logic              shift_evt,
  output logic              irq
);
  logic [1:0]            rst_pipe_q;
  logic                  rst_int_n;
  logic [NLINE-1:0]      lines, rise, fall;
  logic [NPORT-1:0]      port_acc;
  logic [NSRC-1:0]       set_vec, port_clr_vec, flags_w, enables_w;
  logic [DATA_W-1:0]     cfg_w;
  port_cfg_t [NPORT-1:0] pcfg;
  reg_sel_e              sel;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // line order: per port, primary at 2g, secondary at 2g+1
  assign lines    = {line_b_sec, line_b_pri, line_a_sec, line_a_pri};
  assign port_acc = {port_b_access, port_a_access};
  assign sel      = reg_sel_e'(addr[1:0]);

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    irqflag_edge #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)) edge_i (
      .clk(clk), .rst_n(rst_int_n), .line_in(lines[l]),
      .rise(rise[l]), .fall(fall[l])
    );
  end

  irqflag_lcfg lcfg_i (.cfg(cfg_w), .port_cfg(pcfg));

  // port g: primary flag at 3g+1, secondary flag at 3g
  always_comb begin
    set_vec      = '0;
    port_clr_vec = '0;
    for (int g = 0; g < NPORT; g++) begin
      set_vec[3*g+1]      = pcfg[g].pri_rise ? rise[2*g] : fall[2*g];
      set_vec[3*g]        = pcfg[g].sec_on &
                            (pcfg[g].sec_rise ? rise[2*g+1] : fall[2*g+1]);
      port_clr_vec[3*g+1] = port_acc[g];
      port_clr_vec[3*g]   = port_acc[g] & ~pcfg[g].sec_indep;
    end
    set_vec[SRC_SHIFT] = shift_evt;
    set_vec[SRC_TMR2]  = tmr2_evt;
    set_vec[SRC_TMR1]  = tmr1_evt;
  end

  irqflag_regs #(.CLR_NEEDS_B7(CLR_NEEDS_B7)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .set_vec(set_vec), .port_clr_vec(port_clr_vec),
    .flags(flags_w), .enables(enables_w), .cfg(cfg_w),
    .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/irqflag_chk.sv
module irqflag_chk #(
  parameter int unsigned ADDR_W       = 2,
  parameter bit          CLR_NEEDS_B7 = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              port_a_access,
  input logic              port_b_access,
  input logic              tmr1_evt,
  input logic              irq,
  input logic [6:0]        flags,
  input logic [6:0]        enables
);
  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] == 2'd1 && wdata[7])
      |=> ((enables & $past(wdata[6:0])) == $past(wdata[6:0])));

  // R3
  enable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] == 2'd1 && !wdata[7])
      |=> ((enables & $past(wdata[6:0])) == 7'd0));

  // R2
  enable_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] == 2'd1) |=> rd_data[7]);

  // R6
  pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] == 2'd0) |=> (rd_data[7] == $past(irq)));

  // R7
  tmr1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_evt |=> flags[6]);

  // R5
  clr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CLR_NEEDS_B7 && wr_en && addr[1:0] == 2'd0 && !wdata[7]
      && !port_a_access && !port_b_access)
      |=> (($past(flags) & ~flags) == 7'd0));
endmodule

bind irqflag_ctrl irqflag_chk #(.ADDR_W(ADDR_W), .CLR_NEEDS_B7(CLR_NEEDS_B7)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rd_data(rd_data), .port_a_access(port_a_access),
  .port_b_access(port_b_access), .tmr1_evt(tmr1_evt), .irq(irq),
  .flags(flags_w), .enables(enables_w)
);

// File: tb/irqflag_ctrl_tb_top.sv
module irqflag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic       la_p = 1'b1, la_s = 1'b1, lb_p = 1'b1, lb_s = 1'b1;
  logic       pa_acc = 1'b0, pb_acc = 1'b0;
  logic       t1 = 1'b0, t2 = 1'b0, sh = 1'b0;
  logic [7:0] rd_data, rd_data_v;
  logic       irq, irq_v;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] rv, rvv;

  always #10 clk = ~clk;

  irqflag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .line_a_pri(la_p), .line_a_sec(la_s),
    .line_b_pri(lb_p), .line_b_sec(lb_s), .port_a_access(pa_acc),
    .port_b_access(pb_acc), .tmr1_evt(t1), .tmr2_evt(t2), .shift_evt(sh),
    .irq(irq)
  );

  irqflag_ctrl #(.CLR_NEEDS_B7(1'b1)) dut_v (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data_v), .line_a_pri(la_p), .line_a_sec(la_s),
    .line_b_pri(lb_p), .line_b_sec(lb_s), .port_a_access(pa_acc),
    .port_b_access(pb_acc), .tmr1_evt(t1), .tmr2_evt(t2), .shift_evt(sh),
    .irq(irq_v)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    rv = rd_data; rvv = rd_data_v;
  endtask

  task automatic settle3();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd0); chk("R1 flags", rv, 8'h00);
    rd(2'd1); chk("R1 enables", rv, 8'h80);
    rd(2'd2); chk("R1 cfg", rv, 8'h00);
  endtask

  task automatic t_enables();
    wr(2'd1, 8'h85); rd(2'd1); chk("R2 set", rv, 8'h85);
    wr(2'd1, 8'h82); rd(2'd1); chk("R2 keep", rv, 8'h87);
    wr(2'd1, 8'h05); rd(2'd1); chk("R3 clear some", rv, 8'h82);
    wr(2'd1, 8'h7F); rd(2'd1); chk("R3 clear all", rv, 8'h80);
  endtask

  task automatic t_events();
    t1 = 1'b1; @(negedge clk); t1 = 1'b0;
    t2 = 1'b1; sh = 1'b1; @(negedge clk); t2 = 1'b0; sh = 1'b0;
    rd(2'd0); chk("R7 events", rv, 8'h64);
    chk("R12 irq masked", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'hC0);
    chk("R12 irq on enable", {7'd0, irq}, 8'h01);
    rd(2'd0); chk("R6 pend bit", rv, 8'hE4);
    wr(2'd0, 8'h40);
    chk("R6 irq drops", {7'd0, irq}, 8'h00);
    rd(2'd0); chk("R4 clear one", rv, 8'h24);
    wr(2'd0, 8'h7F); rd(2'd0); chk("R4 clear all", rv, 8'h00);
    wr(2'd1, 8'h7F);
  endtask

  task automatic t_collision();
    addr = 2'd0; wdata = 8'h20; wr_en = 1'b1; t2 = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; t2 = 1'b0;
    rd(2'd0); chk("R11 event wins", rv, 8'h20);
    wr(2'd0, 8'h7F);
  endtask

  task automatic t_primary();
    wr(2'd2, 8'h00);
    la_p = 1'b0; settle3(); rd(2'd0); chk("R8 A falling", rv, 8'h02);
    wr(2'd0, 8'h7F);
    la_p = 1'b1; settle3(); rd(2'd0); chk("R8 A rise ignored", rv, 8'h00);
    wr(2'd2, 8'h11);
    la_p = 1'b0; lb_p = 1'b0; settle3(); rd(2'd0); chk("R8 fall ignored", rv, 8'h00);
    la_p = 1'b1; lb_p = 1'b1; settle3(); rd(2'd0); chk("R8 rising A B", rv, 8'h12);
    wr(2'd0, 8'h7F); wr(2'd2, 8'h00);
  endtask

  task automatic t_secondary();
    wr(2'd2, 8'h66);
    la_s = 1'b0; lb_s = 1'b0; settle3(); rd(2'd0); chk("R9 0x66 fall ignored", rv, 8'h00);
    la_s = 1'b1; lb_s = 1'b1; settle3(); rd(2'd0); chk("R9 0x66 rising", rv, 8'h09);
    wr(2'd0, 8'h7F); wr(2'd2, 8'h22);
    la_s = 1'b0; lb_s = 1'b0; settle3(); rd(2'd0); chk("R9 0x22 falling", rv, 8'h09);
    wr(2'd0, 8'h7F);
    la_s = 1'b1; lb_s = 1'b1; settle3(); rd(2'd0); chk("R9 0x22 rise ignored", rv, 8'h00);
    wr(2'd2, 8'h88);
    la_s = 1'b0; lb_s = 1'b0; settle3(); rd(2'd0); chk("R9 output mode fall", rv, 8'h00);
    la_s = 1'b1; lb_s = 1'b1; settle3(); rd(2'd0); chk("R9 output mode rise", rv, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_port();
    wr(2'd2, 8'h22);
    la_p = 1'b0; la_s = 1'b0; lb_p = 1'b0; lb_s = 1'b0;
    settle3(); rd(2'd0); chk("R10 setup", rv, 8'h1B);
    pa_acc = 1'b1; @(negedge clk); pa_acc = 1'b0;
    rd(2'd0); chk("R10 A indep kept", rv, 8'h19);
    wr(2'd2, 8'h02);
    pb_acc = 1'b1; @(negedge clk); pb_acc = 1'b0;
    rd(2'd0); chk("R10 B non-indep cleared", rv, 8'h01);
    wr(2'd0, 8'h7F);
    la_p = 1'b1; la_s = 1'b1; lb_p = 1'b1; lb_s = 1'b1; settle3();
    wr(2'd2, 8'h00);
    la_s = 1'b0; settle3(); rd(2'd0); chk("R10 A sec set", rv, 8'h01);
    pa_acc = 1'b1; @(negedge clk); pa_acc = 1'b0;
    rd(2'd0); chk("R10 A non-indep cleared", rv, 8'h00);
    la_s = 1'b1; settle3();
  endtask

  task automatic t_variant();
    wr(2'd1, 8'h7F); wr(2'd0, 8'hFF);
    t1 = 1'b1; @(negedge clk); t1 = 1'b0;
    wr(2'd0, 8'h40);
    rd(2'd0);
    chk("R4 default clears", rv, 8'h00);
    chk("R5 variant keeps", rvv, 8'h40);
    wr(2'd0, 8'hC0);
    rd(2'd0); chk("R5 variant clears with bit7", rvv, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enables();
    t_events();
    t_collision();
    t_primary();
    t_secondary();
    t_port();
    t_variant();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule